// File: doc/BRIEF.md
# Alignment Character Monitor with Resynchronization Request

This block sits on one receive lane after the 10b/8b decoder and the descrambler. Once user data begins, it tracks frame and multiframe boundaries with its own counters. On every accepted octet it checks where the two alignment control characters fall. The frame-end marker is a control octet 0xFC (K28.7). The multiframe-end marker is a control octet 0x7C (K28.3).

A marker found in a legal position is turned back into the data octet that the transmitter replaced. In scrambled mode the restored octet is the marker's own value. In unscrambled mode it is the last restored octet of the previous frame.

A marker in any other position is counted as a misplaced character. It raises a one-cycle error flag and increments a saturating error count. It also pulls an active-low synchronization request low for five local frames, so that the far end restarts the link.

Top module: `aln_monitor`

## Requirements
- R1: Under synchronous reset the outputs are out_valid=0, out_err=0, sync_n=1 and err_count=0.
- R2: Until a data_start pulse has been seen, every input octet is ignored: no out_valid and no out_err. The octet presented in the same cycle as data_start is also ignored.
- R3: data_start sets both positions to zero. A frame holds cfg_frame_m1+1 octets and a multiframe holds cfg_mf_m1+1 frames. Each accepted octet appears on out_octet with out_valid exactly one cycle after it is sampled.
- R4: A control octet 0xFC in the last position of a frame is legal. In scrambled mode (scrambled=1) it is output as data 0xFC with out_k=0.
- R5: A control octet 0x7C in the last position of a multiframe is legal. In scrambled mode it is output as data 0x7C with out_k=0.
- R6: In unscrambled mode a legal 0xFC or 0x7C control octet is output, with out_k=0, as the restored last octet of the previous frame. That value is 0x00 if no frame has ended since data_start.
- R7: A control 0xFC outside a frame end, or a control 0x7C outside a multiframe end, raises out_err for exactly that octet's output cycle. The octet is passed unchanged with out_k=1.
- R8: sync_n goes low in the cycle out_err is raised. It returns high in the output cycle of the fifth subsequent frame-last octet. A new error during that window restarts the count at five.
- R9: err_count increases by one with each out_err and holds at its all-ones value instead of wrapping.
- R10: Data octets, and control octets other than legal alignment markers, pass through with their value and K flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_start | input | 1 | Pulse marking the start of user data |
| in_valid | input | 1 | Input octet qualifier |
| in_octet | input | 8 | Decoded octet |
| in_is_k | input | 1 | Control-character flag for in_octet |
| scrambled | input | 1 | 1 = scrambled link, 0 = unscrambled |
| cfg_frame_m1 | input | $clog2(F_MAX) | Octets per frame minus one |
| cfg_mf_m1 | input | $clog2(K_MAX) | Frames per multiframe minus one |
| out_valid | output | 1 | Output octet qualifier |
| out_octet | output | 8 | Restored octet |
| out_k | output | 1 | Control flag of the restored octet |
| out_err | output | 1 | One-cycle misplaced-character flag |
| sync_n | output | 1 | Active-low resynchronization request |
| err_count | output | ERR_W | Saturating error count |

## Verification
The assertions take for granted that scrambled, cfg_frame_m1 and cfg_mf_m1 stay constant from data_start until the next reset, and that data_start is not pulsed again while the monitor is running. The stimulus respects both: it changes mode and lengths only inside a reset and raises data_start once per phase. Within a phase the octets are drawn from $urandom with a fixed seed, with a bias towards alignment markers in both legal and illegal positions. Directed multiframes are mixed in to cover legal restoration, and a one-octet frame is used as the extreme length setting.

// File: rtl/aln_pkg.sv
package aln_pkg;
  localparam logic [7:0] FRAME_MARK = 8'hFC;
  localparam logic [7:0] MF_MARK    = 8'h7C;
endpackage

// File: rtl/aln_pos_tracker.sv
module aln_pos_tracker #(
  parameter int F_MAX = 16,
  parameter int K_MAX = 32,
  localparam int FPW = $clog2(F_MAX),
  localparam int KPW = $clog2(K_MAX)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           data_start,
  input  logic           in_valid,
  input  logic [FPW-1:0] cfg_frame_m1,
  input  logic [KPW-1:0] cfg_mf_m1,
  output logic           accept,
  output logic           at_eof,
  output logic           at_eom
);
  logic           active_q;
  logic [FPW-1:0] opos_q;
  logic [KPW-1:0] fpos_q;

  assign accept = in_valid && active_q && !data_start;
  assign at_eof = (opos_q == cfg_frame_m1);
  assign at_eom = at_eof && (fpos_q == cfg_mf_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      opos_q   <= '0;
      fpos_q   <= '0;
    end else if (data_start) begin
      active_q <= 1'b1;
      opos_q   <= '0;
      fpos_q   <= '0;
    end else if (accept) begin
      if (at_eof) begin
        opos_q <= '0;
        fpos_q <= at_eom ? '0 : fpos_q + 1'b1;
      end else begin
        opos_q <= opos_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/aln_restore.sv
module aln_restore
  import aln_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       data_start,
  input  logic       accept,
  input  logic       at_eof,
  input  logic       at_eom,
  input  logic       scrambled,
  input  logic [7:0] in_octet,
  input  logic       in_is_k,
  output logic [7:0] rest_octet,
  output logic       rest_k,
  output logic       misplaced
);
  logic [7:0] last_q;
  logic       is_fm, is_mm, legal;

  assign is_fm     = in_is_k && (in_octet == FRAME_MARK);
  assign is_mm     = in_is_k && (in_octet == MF_MARK);
  assign legal     = (is_fm && at_eof) || (is_mm && at_eom);
  assign misplaced = accept && ((is_fm && !at_eof) || (is_mm && !at_eom));

  always_comb begin
    rest_octet = in_octet;
    rest_k     = in_is_k;
    if (legal) begin
      rest_k = 1'b0;
      if (!scrambled) rest_octet = last_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || data_start) last_q <= '0;
    else if (accept && at_eof) last_q <= rest_octet;
  end
endmodule

// File: rtl/aln_sync_timer.sv
module aln_sync_timer #(
  parameter int SYNC_FRAMES = 5,
  parameter int ERR_W = 8,
  localparam int HW = $clog2(SYNC_FRAMES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             misplaced,
  input  logic             frame_end,
  output logic             sync_n,
  output logic [ERR_W-1:0] err_count
);
  logic [HW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      sync_n <= 1'b1;
    end else if (misplaced) begin
      hold_q <= HW'(SYNC_FRAMES);
      sync_n <= 1'b0;
    end else if (frame_end && hold_q != '0) begin
      hold_q <= hold_q - 1'b1;
      if (hold_q == HW'(1)) sync_n <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) err_count <= '0;
    else if (misplaced && err_count != '1) err_count <= err_count + 1'b1;
  end
endmodule

// File: rtl/aln_monitor.sv
module aln_monitor #(
  parameter int F_MAX = 16,
  parameter int K_MAX = 32,
  parameter int SYNC_FRAMES = 5,
  parameter int ERR_W = 8,
  localparam int FPW = $clog2(F_MAX),
  localparam int KPW = $clog2(K_MAX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             data_start,
  input  logic             in_valid,
  input  logic [7:0]       in_octet,
  input  logic             in_is_k,
  input  logic             scrambled,
  input  logic [FPW-1:0]   cfg_frame_m1,
  input  logic [KPW-1:0]   cfg_mf_m1,
  output logic             out_valid,
  output logic [7:0]       out_octet,
  output logic             out_k,
  output logic             out_err,
  output logic             sync_n,
  output logic [ERR_W-1:0] err_count
);
  logic       accept, at_eof, at_eom, acc_eof;
  logic [7:0] rest_octet;
  logic       rest_k, misplaced;

  assign acc_eof = accept && at_eof;

  aln_pos_tracker #(.F_MAX(F_MAX), .K_MAX(K_MAX)) u_trk (
    .clk(clk), .rst(rst), .data_start(data_start), .in_valid(in_valid),
    .cfg_frame_m1(cfg_frame_m1), .cfg_mf_m1(cfg_mf_m1),
    .accept(accept), .at_eof(at_eof), .at_eom(at_eom)
  );

  aln_restore u_rst (
    .clk(clk), .rst(rst), .data_start(data_start), .accept(accept),
    .at_eof(at_eof), .at_eom(at_eom), .scrambled(scrambled),
    .in_octet(in_octet), .in_is_k(in_is_k),
    .rest_octet(rest_octet), .rest_k(rest_k), .misplaced(misplaced)
  );

  aln_sync_timer #(.SYNC_FRAMES(SYNC_FRAMES), .ERR_W(ERR_W)) u_tmr (
    .clk(clk), .rst(rst), .misplaced(misplaced), .frame_end(acc_eof),
    .sync_n(sync_n), .err_count(err_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_octet <= '0;
      out_k     <= 1'b0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= accept;
      out_err   <= misplaced;
      if (accept) begin
        out_octet <= rest_octet;
        out_k     <= rest_k;
      end
    end
  end
endmodule

// File: rtl/aln_monitor_chk.sv
module aln_monitor_chk #(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             acc_eof,
  input logic             out_valid,
  input logic [7:0]       out_octet,
  input logic             out_k,
  input logic             out_err,
  input logic             sync_n,
  input logic [ERR_W-1:0] err_count
);
  a_r2_valid_needs_input: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  a_r7_err_with_octet: assert property (@(posedge clk) disable iff (rst)
    out_err |-> (out_valid && out_k));

  a_r4_no_marker_restored_as_k: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_k && !out_err) |-> (out_octet != 8'hFC && out_octet != 8'h7C));

  a_r8_err_drops_sync: assert property (@(posedge clk) disable iff (rst)
    out_err |-> !sync_n);

  a_r8_release_on_frame_end: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_n) |-> $past(acc_eof));

  a_r9_count_steps: assert property (@(posedge clk) disable iff (rst)
    out_err |-> (err_count == $past(err_count) + 1'b1 || $past(err_count) == '1));

  a_r9_count_holds: assert property (@(posedge clk) disable iff (rst)
    !out_err |-> $stable(err_count));
endmodule

bind aln_monitor aln_monitor_chk #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .acc_eof(acc_eof),
  .out_valid(out_valid), .out_octet(out_octet), .out_k(out_k),
  .out_err(out_err), .sync_n(sync_n), .err_count(err_count)
);

// File: tb/aln_monitor_test.sv
module aln_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int ERR_W = 4;
  localparam int FPW = 4;
  localparam int KPW = 5;

  logic clk = 1'b0, rst = 1'b1, data_start = 1'b0, in_valid = 1'b0;
  logic [7:0] in_octet = '0;
  logic in_is_k = 1'b0, scrambled = 1'b1;
  logic [FPW-1:0] cfg_frame_m1 = '0;
  logic [KPW-1:0] cfg_mf_m1 = '0;
  logic out_valid, out_k, out_err, sync_n;
  logic [7:0] out_octet;
  logic [ERR_W-1:0] err_count;

  aln_monitor #(.F_MAX(16), .K_MAX(32), .SYNC_FRAMES(5), .ERR_W(ERR_W)) uut (
    .clk(clk), .rst(rst), .data_start(data_start), .in_valid(in_valid),
    .in_octet(in_octet), .in_is_k(in_is_k), .scrambled(scrambled),
    .cfg_frame_m1(cfg_frame_m1), .cfg_mf_m1(cfg_mf_m1),
    .out_valid(out_valid), .out_octet(out_octet), .out_k(out_k),
    .out_err(out_err), .sync_n(sync_n), .err_count(err_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit pend = 0;
  bit m_active;
  int m_opos, m_fpos, m_hold, m_cnt, fl, kl;
  logic [7:0] m_last;
  logic m_sync;
  logic e_valid, e_k, e_err;
  logic [7:0] e_oct;
  string e_tag;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk(m_active ? "R3 out_valid" : "R2 out_valid", out_valid, e_valid);
    if (e_valid) begin
      chk({e_tag, " out_octet"}, out_octet, e_oct);
      chk({e_tag, " out_k"}, out_k, e_k);
    end
    chk("R7 out_err", out_err, e_err);
    chk("R8 sync_n", sync_n, m_sync);
    chk("R9 err_count", err_count, m_cnt);
  endtask

  task automatic step(input logic v, input logic [7:0] o, input logic k, input logic ds);
    bit eof, eom, isf, ism, err, rest;
    @(negedge clk);
    if (pend) compare();
    in_valid = v; in_octet = o; in_is_k = k; data_start = ds;
    e_valid = 0; e_err = 0;
    if (ds) begin
      m_active = 1; m_opos = 0; m_fpos = 0; m_last = 8'h00;
    end else if (v && m_active) begin
      eof = (m_opos == fl - 1);
      eom = eof && (m_fpos == kl - 1);
      isf = k && o == 8'hFC;
      ism = k && o == 8'h7C;
      err = (isf && !eof) || (ism && !eom);
      rest = (isf || ism) && !err;
      e_valid = 1; e_err = err;
      e_oct = rest ? (scrambled ? o : m_last) : o;
      e_k = k && !rest;
      e_tag = err ? "R7" : !rest ? "R10" : !scrambled ? "R6" : isf ? "R4" : "R5";
      if (eof) m_last = e_oct;
      if (err) begin
        m_hold = 5; m_sync = 0;
        if (m_cnt < (1 << ERR_W) - 1) m_cnt++;
      end else if (eof && m_hold > 0) begin
        m_hold--;
        if (m_hold == 0) m_sync = 1;
      end
      if (eof) begin
        m_opos = 0;
        m_fpos = eom ? 0 : m_fpos + 1;
      end else m_opos++;
    end
    pend = 1;
  endtask

  task automatic phase(input logic scr, input int f, input int kk, input int nrand);
    logic [7:0] o;
    logic k;
    int r;
    @(negedge clk);
    rst = 1; in_valid = 0; data_start = 0; pend = 0;
    scrambled = scr; cfg_frame_m1 = FPW'(f - 1); cfg_mf_m1 = KPW'(kk - 1);
    fl = f; kl = kk;
    m_active = 0; m_hold = 0; m_sync = 1; m_cnt = 0; m_last = 0; m_opos = 0; m_fpos = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 out_err", out_err, 0);
    chk("R1 sync_n", sync_n, 1);
    chk("R1 err_count", err_count, 0);
    // R2: markers before data_start are ignored
    for (int i = 0; i < 6; i++) step(1, (i % 2) ? 8'h7C : 8'hFC, 1, 0);
    step(1, 8'hFC, 1, 1);
    // directed legal multiframes
    for (int fr = 0; fr < 2 * kk; fr++)
      for (int p = 0; p < f; p++) begin
        if (p == f - 1) step(1, (fr % kk == kk - 1) ? 8'h7C : 8'hFC, 1, 0);
        else step(1, 8'(fr * 16 + p + 1), 0, 0);
      end
    for (int i = 0; i < nrand; i++) begin
      r = $urandom_range(0, 99);
      k = 0; o = 8'($urandom);
      if (r < 4) begin o = 8'hFC; k = 1; end
      else if (r < 7) begin o = 8'h7C; k = 1; end
      else if (r < 10) begin o = 8'hBC; k = 1; end
      else if (r < 14) begin o = 8'hFC; k = 0; end
      if (r >= 95) step(0, o, k, 0);
      else step(1, o, k, 0);
    end
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    phase(1, 4, 3, 800);
    phase(0, 3, 2, 800);
    phase(0, 1, 1, 300);
    phase(1, 16, 32, 1200);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule